// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table kept in a word-addressed memory. A requester hands it a 32-bit virtual address, a read/write indication and the frame number of the top-level table. The walker reads the top-level entry, follows it to the second-level table, reads the leaf entry and answers with the physical address and the leaf's flags. If either entry is marked not present, it answers with a page fault instead.

A successful walk also maintains the leaf's bookkeeping bits. Every reference marks the page as used, and a write reference also marks it dirty. The leaf word goes back to memory only when one of those bits actually changes. The state machine moves through six states. `ST_IDLE` takes a request. `ST_READ_L1` and `ST_READ_L2` fetch the two entries. `ST_UPDATE` writes the leaf back. `ST_DONE` and `ST_FAULT` each return a one-cycle response and go back to `ST_IDLE`.

The transitions are as follows:
- Request accepted: IDLE→READ_L1.
- Top-level entry present: READ_L1→READ_L2.
- Top-level entry not present: READ_L1→FAULT.
- Leaf not present: READ_L2→FAULT.
- Leaf bits change: READ_L2→UPDATE.
- Leaf bits already set: READ_L2→DONE.
- Write-back complete: UPDATE→DONE.
- Response given: DONE/FAULT→IDLE.

Every memory access holds its request until the memory signals ready.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `resp_valid` and `mem_req` are 0.
- R2: The virtual address splits into a top-level index (bits 31:22), a second-level index (bits 21:12) and a page offset (bits 11:0). The first read uses word address {`req_root`, bits 31:22}. The second read uses word address {frame field of the top-level entry, bits 21:12}.
- R3: An entry is a 32-bit word. Bits 31:12 hold the frame number, bit 0 is present, bit 1 is used and bit 2 is dirty. Bits 11:3 are ignored.
- R4: A top-level entry with bit 0 clear ends the walk after one read. The response has `resp_fault`=1, `resp_fault_lvl`=0, and `resp_paddr` and `resp_flags` are zero. No memory write occurs.
- R5: A leaf entry with bit 0 clear ends the walk after two reads. The response has `resp_fault`=1 and `resp_fault_lvl`=1, and no memory write occurs.
- R6: A successful walk responds with `resp_fault`=0, `resp_paddr` = {leaf frame, page offset} and `resp_flags` = the leaf's bits 2:0 after update.
- R7: A successful walk sets the used bit. When `req_write`=1 it also sets the dirty bit. Other leaf bits keep their values.
- R8: The leaf is written back exactly once, to the address it was read from, when the update changes it. It is not written at all when the update leaves it unchanged. The top-level entry is never written.
- R9: While `mem_req`=1 and `mem_ready`=0, the request, address, write enable and write data hold steady on the next cycle. Any number of stall cycles is tolerated.
- R10: A request is accepted only while `req_ready`=1, which holds only in the idle state. A `req_valid` held high during a walk starts no further memory access.
- R11: `resp_valid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request taken when both high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Reference is a write |
| req_root | input | 20 | Frame number of the top-level table |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Walk ended in a page fault |
| resp_fault_lvl | output | 1 | Level of the faulting entry (0 top, 1 leaf) |
| resp_paddr | output | 32 | Physical address on success |
| resp_flags | output | 3 | Updated dirty/used/present bits on success |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the ready cycle |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The sweep crosses both levels of present bit with all eight leaf flag combinations, with reads and writes, and with zero, one and two memory stall cycles. Index and offset values include all-ones and all-zeros. A walker that skipped the write-back elision would store already-set leaves again. One that forgot the dirty bit on writes would return flags and memory words that disagree with the arithmetic expectation. A walker that mixed up the index fields would read the wrong word and return the wrong frame. A walker that dropped its address during a stall would miss the memory-side stall assertions. Holding `req_valid` high through a walk catches a walker that re-accepts while busy, because an extra memory read would appear.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int LEVELS = 2;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_USED    = 1;
    localparam int BIT_DIRTY   = 2;
    localparam int FLAG_W      = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_L1,
        ST_READ_L2,
        ST_UPDATE,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

endpackage

// File: rtl/ptw_index_unit.sv
module ptw_index_unit #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input  logic [2*IDX_W+OFF_W-1:0]       vaddr,
    input  logic [PTE_W-OFF_W-1:0]         root_frame,
    input  logic [PTE_W-OFF_W-1:0]         leaf_table_frame,
    output logic [PTE_W-OFF_W+IDX_W-1:0]   l1_addr,
    output logic [PTE_W-OFF_W+IDX_W-1:0]   l2_addr,
    output logic [OFF_W-1:0]               page_off
);
    import ptw_pkg::*;

    logic [IDX_W-1:0] level_idx [LEVELS];

    // Level 0 takes the most significant index field.
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_idx
        localparam int LSB = OFF_W + (LEVELS - 1 - lv) * IDX_W;
        assign level_idx[lv] = vaddr[LSB +: IDX_W];
    end

    assign l1_addr  = {root_frame, level_idx[0]};
    assign l2_addr  = {leaf_table_frame, level_idx[1]};
    assign page_off = vaddr[OFF_W-1:0];

endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval #(
    parameter int PTE_W = 32,
    parameter int OFF_W = 12
) (
    input  logic [PTE_W-1:0]       entry,
    input  logic                   is_write,
    output logic                   present,
    output logic [PTE_W-OFF_W-1:0] frame,
    output logic [PTE_W-1:0]       marked,
    output logic                   changed
);
    import ptw_pkg::*;

    logic [PTE_W-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        set_mask[BIT_USED] = 1'b1;
        if (is_write) begin
            set_mask[BIT_DIRTY] = 1'b1;
        end
    end

    assign present = entry[BIT_PRESENT];
    assign frame   = entry[PTE_W-1:OFF_W];
    assign marked  = entry | set_mask;
    assign changed = (marked != entry);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [2*IDX_W+OFF_W-1:0]            req_vaddr,
    input  logic                                req_write,
    input  logic [PTE_W-OFF_W-1:0]              req_root,
    output logic                                resp_valid,
    output logic                                resp_fault,
    output logic                                resp_fault_lvl,
    output logic [PTE_W-1:0]                    resp_paddr,
    output logic [2:0]                          resp_flags,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [PTE_W-OFF_W+IDX_W-1:0]        mem_addr,
    output logic [PTE_W-1:0]                    mem_wdata,
    input  logic [PTE_W-1:0]                    mem_rdata,
    input  logic                                mem_ready
);
    import ptw_pkg::*;

    localparam int VA_W    = 2 * IDX_W + OFF_W;
    localparam int FRAME_W = PTE_W - OFF_W;
    localparam int MADDR_W = FRAME_W + IDX_W;

    walk_state_t state_q, state_d;

    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic [FRAME_W-1:0] root_q;
    logic [FRAME_W-1:0] table_q;
    logic [PTE_W-1:0]   leaf_q;

    logic [MADDR_W-1:0] l1_addr, l2_addr;
    logic [OFF_W-1:0]   page_off;

    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;
    logic [PTE_W-1:0]   ent_marked;
    logic               ent_changed;

    logic               accept;
    logic               xfer_done;

    ptw_index_unit #(
        .IDX_W (IDX_W),
        .OFF_W (OFF_W),
        .PTE_W (PTE_W)
    ) u_index (
        .vaddr            (va_q),
        .root_frame       (root_q),
        .leaf_table_frame (table_q),
        .l1_addr          (l1_addr),
        .l2_addr          (l2_addr),
        .page_off         (page_off)
    );

    ptw_entry_eval #(
        .PTE_W (PTE_W),
        .OFF_W (OFF_W)
    ) u_eval (
        .entry    (mem_rdata),
        .is_write (wr_q),
        .present  (ent_present),
        .frame    (ent_frame),
        .marked   (ent_marked),
        .changed  (ent_changed)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign xfer_done = mem_req && mem_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_READ_L1;
                end
            end
            ST_READ_L1: begin
                if (mem_ready) begin
                    state_d = ent_present ? ST_READ_L2 : ST_FAULT;
                end
            end
            ST_READ_L2: begin
                if (mem_ready) begin
                    if (!ent_present) begin
                        state_d = ST_FAULT;
                    end else if (ent_changed) begin
                        state_d = ST_UPDATE;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_UPDATE: begin
                if (mem_ready) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Walk context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q           <= '0;
            wr_q           <= 1'b0;
            root_q         <= '0;
            table_q        <= '0;
            leaf_q         <= '0;
            resp_fault_lvl <= 1'b0;
        end else begin
            if (accept) begin
                va_q           <= req_vaddr;
                wr_q           <= req_write;
                root_q         <= req_root;
                resp_fault_lvl <= 1'b0;
            end
            if (state_q == ST_READ_L1 && xfer_done) begin
                table_q <= ent_frame;
            end
            if (state_q == ST_READ_L2 && xfer_done) begin
                leaf_q         <= ent_marked;
                resp_fault_lvl <= 1'b1;
            end
        end
    end

    // Output logic
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_fault = 1'b0;
        resp_paddr = '0;
        resp_flags = '0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_READ_L1: begin
                mem_req  = 1'b1;
                mem_addr = l1_addr;
            end
            ST_READ_L2: begin
                mem_req  = 1'b1;
                mem_addr = l2_addr;
            end
            ST_UPDATE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = l2_addr;
                mem_wdata = leaf_q;
            end
            ST_DONE: begin
                resp_valid = 1'b1;
                resp_paddr = {leaf_q[PTE_W-1:OFF_W], page_off};
                resp_flags = leaf_q[FLAG_W-1:0];
            end
            ST_FAULT: begin
                resp_valid = 1'b1;
                resp_fault = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PTE_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          resp_valid,
    input logic                          resp_fault,
    input logic [PTE_W-1:0]              resp_paddr,
    input logic [2:0]                    resp_flags,
    input logic                          mem_req,
    input logic                          mem_we,
    input logic [PTE_W-OFF_W+IDX_W-1:0]  mem_addr,
    input logic [PTE_W-1:0]              mem_wdata,
    input logic                          mem_ready
);

    // R9: a stalled access keeps its request and address
    a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R10: once a request is taken, the walker is busy on the next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R10: no memory traffic while idle
    a_r10_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req && !resp_valid);

    // R11: response lasts one cycle
    a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R7: a write-back always carries present and used set
    a_r7_writeback_marked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[0] && mem_wdata[1]);

    // R6: a successful response reports a present, used page
    a_r6_ok_flags: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_fault |-> resp_flags[0] && resp_flags[1]);

    // R4: a fault response carries no translation
    a_r4_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> resp_paddr == '0 && resp_flags == '0);

endmodule

bind ptw_walker ptw_walker_chk #(
    .IDX_W (IDX_W),
    .OFF_W (OFF_W),
    .PTE_W (PTE_W)
) u_chk (.*);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    localparam int IDX_W   = 10;
    localparam int OFF_W   = 12;
    localparam int PTE_W   = 32;
    localparam int VA_W    = 2 * IDX_W + OFF_W;
    localparam int FRAME_W = PTE_W - OFF_W;
    localparam int MADDR_W = FRAME_W + IDX_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n;
    logic               req_valid, req_ready, req_write;
    logic [VA_W-1:0]    req_vaddr;
    logic [FRAME_W-1:0] req_root;
    logic               resp_valid, resp_fault, resp_fault_lvl;
    logic [PTE_W-1:0]   resp_paddr;
    logic [2:0]         resp_flags;
    logic               mem_req, mem_we, mem_ready;
    logic [MADDR_W-1:0] mem_addr;
    logic [PTE_W-1:0]   mem_wdata, mem_rdata;

    ptw_walker #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_W(PTE_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_root(req_root),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl),
        .resp_paddr(resp_paddr), .resp_flags(resp_flags),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Memory model: 4096 words, one process owns all of its state
    logic [PTE_W-1:0]   mem [0:4095];
    int                 stall_cfg, wait_cnt, rd_cnt, wr_cnt;
    logic [MADDR_W-1:0] rd_addr [0:3];
    logic [MADDR_W-1:0] wr_addr;
    logic               host_we, host_clr;
    logic [11:0]        host_addr;
    logic [PTE_W-1:0]   host_data;

    assign mem_ready = mem_req && (wait_cnt >= stall_cfg);
    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_data;
        if (host_clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
            wait_cnt <= 0;
        end else if (mem_req && mem_ready) begin
            wait_cnt <= 0;
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                wr_addr <= mem_addr;
            end else begin
                if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end else if (mem_req) begin
            wait_cnt <= wait_cnt + 1;
        end else begin
            wait_cnt <= 0;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [11:0] a, input logic [PTE_W-1:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic clear_counts();
        @(negedge clk);
        host_clr = 1'b1;
        @(negedge clk);
        host_clr = 1'b0;
    endtask

    task automatic run_walk(input int k, input logic l1v, input logic [2:0] flags,
                            input logic wr, input int stall, input logic hold);
        logic [IDX_W-1:0]   i1, i2;
        logic [OFF_W-1:0]   off;
        logic [VA_W-1:0]    va;
        logic [FRAME_W-1:0] l2f, lf;
        logic [PTE_W-1:0]   l1e, leaf, nleaf;
        logic [MADDR_W-1:0] a1, a2;
        logic               fault_exp, lvl_exp, wb_exp;
        int                 rd_exp, cyc;
        // R2: index fields bits 31:22 and 21:12, offset 11:0
        if (k % 8 == 0) begin
            i1 = '1; i2 = '1; off = '1;
        end else if (k % 8 == 1) begin
            i1 = '0; i2 = '0; off = '0;
        end else begin
            i1  = IDX_W'((k * 37 + 5) % 1024);
            i2  = IDX_W'((k * 91 + 3) % 1024);
            off = OFF_W'((k * 13 + 1) % 4096);
        end
        va  = {i1, i2, off};
        l2f = FRAME_W'(1 + k % 3);
        lf  = FRAME_W'(k * 40503 + 7);
        // R3: frame 31:12, present bit 0, used 1, dirty 2, bits 11:3 ignored
        l1e  = {l2f, 11'(k * 5 + 3), l1v};
        leaf = {lf, 9'(k * 7), flags};
        a1   = {FRAME_W'(0), i1};
        a2   = {l2f, i2};
        nleaf = leaf | 32'h2 | (wr ? 32'h4 : 32'h0);
        fault_exp = !l1v || !flags[0];
        lvl_exp   = l1v;
        rd_exp    = l1v ? 2 : 1;
        wb_exp    = !fault_exp && (nleaf != leaf);

        host_write(a1[11:0], l1e);
        host_write(a2[11:0], leaf);
        stall_cfg = stall;
        clear_counts();

        @(negedge clk);
        req_vaddr = va; req_write = wr; req_root = '0; req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R10 busy after accept", 32'(req_ready), 32'd0);
        if (hold) begin
            req_vaddr = ~va;
            req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0;
        while (!resp_valid && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(resp_valid == 1'b1, "R11 response arrives", 32'(resp_valid), 32'd1);
        chk(resp_fault == fault_exp, fault_exp ? (l1v ? "R5 leaf fault" : "R4 top fault") : "R6 success",
            32'(resp_fault), 32'(fault_exp));
        if (fault_exp) begin
            chk(resp_fault_lvl == lvl_exp, l1v ? "R5 fault level" : "R4 fault level",
                32'(resp_fault_lvl), 32'(lvl_exp));
            chk(resp_paddr == 32'd0, "R4 fault paddr zero", resp_paddr, 32'd0);
        end else begin
            chk(resp_paddr == {lf, off}, "R6 physical address", resp_paddr, {lf, off});
            chk(resp_flags == nleaf[2:0], "R7 response flags", 32'(resp_flags), 32'(nleaf[2:0]));
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, "R11 single pulse", 32'(resp_valid), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk(rd_cnt == rd_exp, hold ? "R10 held request ignored" : "R4 R5 read count",
            32'(rd_cnt), 32'(rd_exp));
        chk(rd_addr[0] == a1, "R2 first read address", 32'(rd_addr[0]), 32'(a1));
        if (l1v) chk(rd_addr[1] == a2, "R2 second read address", 32'(rd_addr[1]), 32'(a2));
        chk(wr_cnt == int'(wb_exp), "R8 write-back count", 32'(wr_cnt), 32'(wb_exp));
        if (wb_exp) chk(wr_addr == a2, "R8 write-back address", 32'(wr_addr), 32'(a2));
        chk(mem[a2[11:0]] == (wb_exp ? nleaf : leaf), "R7 leaf word in memory",
            mem[a2[11:0]], wb_exp ? nleaf : leaf);
        chk(mem[a1[11:0]] == l1e, "R8 top entry untouched", mem[a1[11:0]], l1e);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0; req_root = '0;
        host_we = 1'b0; host_clr = 1'b0; host_addr = '0; host_data = '0; stall_cfg = 0;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R1 reset response", 32'(resp_valid), 32'd0);
        chk(mem_req == 1'b0, "R1 reset memory request", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0, "R1 idle after reset", 32'(req_ready), 32'd1);
        k = 0;
        for (int v = 0; v < 2; v++) begin
            for (int f = 0; f < 8; f++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int s = 0; s < 3; s++) begin
                        // R9: stall values 0..2 per access
                        run_walk(k, v[0], f[2:0], w[0], s, (k % 5) == 0);
                        k++;
                    end
                end
            end
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule